// File: doc/BRIEF.md
# Multi-Mode Serial Port

A byte-wide serial port in the style of small 8-bit controllers, driven through a tiny register interface. Software writes the data register to launch a frame on the transmit line; a received frame is placed in a receive holding register that is read back from the same address. A control register selects one of four frame/clock modes, carries the receive-enable, the ninth transmit bit, the captured ninth receive bit and the two completion flags. A separate rate register holds a single rate-double bit.

The bit clock comes from one of two places. In the two core-clocked modes it comes from the core clock. In the two timer-clocked modes it comes from overflow strobes of an external timer. A second external timer can take over the bit clock of the timer-clocked modes at a fixed divide of 16. Both completion flags feed one interrupt request, which is masked by an enable input. Timers, vectoring and address filtering live outside the block.

Top module: `sport_port`

## Requirements
- R1: After reset the transmit line is high, the interrupt request is low, and the data, control and rate registers read as 0. Register addresses: 0 data, 1 control, 2 rate (bit 0 = rate-double). Control fields: [7:6] mode, [5] receive-enable, [4] ninth transmit bit, [3] ninth received bit, [2] receive-done, [1] transmit-done, [0] spare storage.
- R2: Mode 1 sends 10 bit times per frame, with each bit lasting DIV_FAST strobes of the first timer when rate-double is 1. Transmit-done reads 1 exactly 10*DIV_FAST cycles after the data-write edge and 0 one cycle earlier, when the strobe is held high.
- R3: Mode 2 sends 11 bit times per frame from the core clock. Each bit lasts DIV_FAST cycles with rate-double at 1, or DIV_SLOW cycles with it at 0. Transmit-done sets 11*div cycles after the data write.
- R4: Mode 3 advances only on first-timer overflow strobes. While the strobe is low, the transmit line holds the start bit and transmit-done stays 0. Once strobes arrive, the frame completes.
- R5: When either second-timer baud-enable bit is set in a timer-clocked mode, the second timer's strobes clock the port at a divide of DIV_FAST, regardless of rate-double.
- R6: A framed transmit puts out a 0 start bit, then the data LSB first, then the ninth transmit bit (modes 2 and 3 only), then a 1 stop bit. The line is high whenever the transmitter is idle.
- R7: Mode 0 shifts out the 8 data bits LSB first with no start or stop bit. Each bit lasts DIV_SHIFT core cycles. Transmit-done sets after 8*DIV_SHIFT cycles.
- R8: In modes 1 to 3, with receive-enable set, a falling edge on the receive line starts a frame. Each bit is sampled at mid-bit. At the frame end the data byte is loaded into the receive register and receive-done is set. In modes 2 and 3 the ninth bit is stored in control bit 3.
- R9: With receive-enable clear, activity on the receive line does not change the receive register or receive-done.
- R10: In mode 0, setting receive-enable while receive-done is clear starts an 8-bit reception at once. The bits are sampled mid-bit every DIV_SHIFT cycles, LSB first, and the byte is loaded with receive-done set.
- R11: The interrupt request equals the interrupt-enable input ANDed with the OR of the two done flags.
- R12: A single-bit write to the control register (bit index, value) updates mode and receive-enable exactly as a whole-register write does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Write address (0 data, 1 control, 2 rate) |
| wr_data_i | input | 8 | Write data |
| bit_wr_i | input | 1 | Single-bit write strobe to control register |
| bit_idx_i | input | 3 | Control bit index for single-bit write |
| bit_val_i | input | 1 | Value for single-bit write |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| t1_ovf_i | input | 1 | First timer overflow strobe |
| t2_ovf_i | input | 1 | Second timer overflow strobe |
| t2_baud_en_i | input | 2 | Second timer receive/transmit clock enables |
| int_en_i | input | 1 | Serial interrupt enable |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The bench builds the port with the default dividers of 12, 16 and 32. As a result, the longest frame (11 bits at a divide of 32) is a few hundred cycles, and every mode, both rate settings and the second-timer override fit in one short run. Holding the timer strobes constantly high makes the timer-clocked modes run at core-clock pace, so completion flags can be checked on the exact cycle. Gating the strobes low shows that the timer-clocked modes depend on them.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'd0,
    MODE_U8_TMR = 2'd1,
    MODE_U9_CLK = 2'd2,
    MODE_U9_TMR = 2'd3
  } sport_mode_e;

  localparam int CB_RX_EN  = 5;
  localparam int CB_TX9    = 4;
  localparam int CB_RX9    = 3;
  localparam int CB_RX_DN  = 2;
  localparam int CB_TX_DN  = 1;

  function automatic logic [3:0] frame_len(sport_mode_e m);
    case (m)
      MODE_SHIFT:  frame_len = 4'd8;
      MODE_U8_TMR: frame_len = 4'd10;
      default:     frame_len = 4'd11;
    endcase
  endfunction
endpackage

// File: rtl/sport_baud.sv
module sport_baud #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             src_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             tick_o,
  output logic             mid_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = src_i && (cnt_q == div_i - CNT_W'(1));
  assign mid_o  = src_i && (cnt_q == (div_i >> 1) - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (src_i)  cnt_q <= tick_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/sport_tx.sv
module sport_tx
  import sport_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [7:0]  data_i,
  input  logic        nine_i,
  input  sport_mode_e mode_i,
  input  logic        tick_i,
  output logic        txd_o,
  output logic        busy_o,
  output logic        done_o
);
  logic [10:0] sr_q;
  logic [3:0]  cnt_q;
  logic [10:0] frame;
  logic        last;

  always_comb begin
    case (mode_i)
      MODE_SHIFT:  frame = {3'b111, data_i};
      MODE_U8_TMR: frame = {2'b11, data_i, 1'b0};
      default:     frame = {1'b1, nine_i, data_i, 1'b0};
    endcase
  end

  assign last   = (cnt_q == frame_len(mode_i) - 4'd1);
  assign done_o = busy_o && tick_i && last && !load_i;
  assign txd_o  = busy_o ? sr_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (load_i) begin
      sr_q   <= frame;
      cnt_q  <= '0;
      busy_o <= 1'b1;
    end else if (busy_o && tick_i) begin
      sr_q <= {1'b1, sr_q[10:1]};
      if (last) busy_o <= 1'b0;
      else      cnt_q  <= cnt_q + 4'd1;
    end
  end
endmodule

// File: rtl/sport_rx.sv
module sport_rx
  import sport_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rxd_i,
  input  logic        en_i,
  input  logic        flag_i,
  input  sport_mode_e mode_i,
  input  logic        tick_i,
  input  logic        mid_i,
  output logic        start_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  data_o,
  output logic        nine_o
);
  logic        rxd_m, rxd_s, rxd_p;
  logic [15:0] samp_q;
  logic [3:0]  cnt_q;
  logic        last;

  // mode 0 starts on enable, framed modes on a falling start edge
  assign start_o = !busy_o && en_i &&
                   ((mode_i == MODE_SHIFT) ? !flag_i : (rxd_p && !rxd_s));
  assign last    = (cnt_q == frame_len(mode_i) - 4'd1);
  assign done_o  = busy_o && tick_i && last;
  assign data_o  = (mode_i == MODE_SHIFT) ? samp_q[7:0] : samp_q[8:1];
  assign nine_o  = samp_q[9];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_m  <= 1'b1;
      rxd_s  <= 1'b1;
      rxd_p  <= 1'b1;
      samp_q <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else begin
      rxd_m <= rxd_i;
      rxd_s <= rxd_m;
      rxd_p <= rxd_s;
      if (start_o) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_o) begin
        if (mid_i) samp_q[cnt_q] <= rxd_s;
        if (tick_i) begin
          if (last) busy_o <= 1'b0;
          else      cnt_q  <= cnt_q + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/sport_port.sv
module sport_port
  import sport_pkg::*;
#(
  parameter int DIV_SHIFT = 12,
  parameter int DIV_FAST  = 16,
  parameter int DIV_SLOW  = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       bit_wr_i,
  input  logic [2:0] bit_idx_i,
  input  logic       bit_val_i,
  input  logic [1:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  input  logic       t1_ovf_i,
  input  logic       t2_ovf_i,
  input  logic [1:0] t2_baud_en_i,
  input  logic       int_en_i,
  input  logic       rxd_i,
  output logic       txd_o,
  output logic       irq_o
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_SHIFT) ?
                           ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST) :
                           ((DIV_SHIFT > DIV_FAST) ? DIV_SHIFT : DIV_FAST);
  localparam int DIV_W = $clog2(DIV_MAX + 1);

  logic [7:0]  ctrl_q, ctrl_d, rx_buf_q;
  logic        dbl_q;
  sport_mode_e mode;
  logic        tmr_mode, t2_sel, bit_src;
  logic [DIV_W-1:0] bit_div;
  logic        tx_load, tx_busy, tx_done;
  logic        rx_start, rx_busy, rx_done, rx_nine;
  logic [7:0]  rx_data;
  logic [1:0]  b_clr, b_tick, b_mid;
  logic        tx_mid_unused;

  assign mode     = sport_mode_e'(ctrl_q[7:6]);
  assign tmr_mode = (mode == MODE_U8_TMR) || (mode == MODE_U9_TMR);
  assign t2_sel   = tmr_mode && (|t2_baud_en_i);
  assign bit_src  = tmr_mode ? (t2_sel ? t2_ovf_i : t1_ovf_i) : 1'b1;

  always_comb begin
    if (mode == MODE_SHIFT)  bit_div = DIV_W'(DIV_SHIFT);
    else if (t2_sel || dbl_q) bit_div = DIV_W'(DIV_FAST);
    else                     bit_div = DIV_W'(DIV_SLOW);
  end

  assign tx_load       = wr_en_i && (addr_i == 2'd0);
  assign b_clr         = {rx_start, tx_load};
  assign tx_mid_unused = b_mid[0];

  for (genvar g = 0; g < 2; g++) begin : g_baud
    sport_baud #(.CNT_W(DIV_W)) u_baud (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (b_clr[g]),
      .src_i  (bit_src),
      .div_i  (bit_div),
      .tick_o (b_tick[g]),
      .mid_o  (b_mid[g])
    );
  end

  sport_tx u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tx_load),
    .data_i (wr_data_i),
    .nine_i (ctrl_q[CB_TX9]),
    .mode_i (mode),
    .tick_i (b_tick[0]),
    .txd_o  (txd_o),
    .busy_o (tx_busy),
    .done_o (tx_done)
  );

  sport_rx u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rxd_i   (rxd_i),
    .en_i    (ctrl_q[CB_RX_EN]),
    .flag_i  (ctrl_q[CB_RX_DN]),
    .mode_i  (mode),
    .tick_i  (b_tick[1]),
    .mid_i   (b_mid[1]),
    .start_o (rx_start),
    .busy_o  (rx_busy),
    .done_o  (rx_done),
    .data_o  (rx_data),
    .nine_o  (rx_nine)
  );

  // hardware flag sets win over a same-cycle software write
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i && addr_i == 2'd1) ctrl_d = wr_data_i;
    if (bit_wr_i) ctrl_d[bit_idx_i] = bit_val_i;
    if (tx_done) ctrl_d[CB_TX_DN] = 1'b1;
    if (rx_done) begin
      ctrl_d[CB_RX_DN] = 1'b1;
      if (ctrl_q[7]) ctrl_d[CB_RX9] = rx_nine;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      rx_buf_q <= '0;
      dbl_q    <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (rx_done) rx_buf_q <= rx_data;
      if (wr_en_i && addr_i == 2'd2) dbl_q <= wr_data_i[0];
    end
  end

  always_comb begin
    case (rd_addr_i)
      2'd0:    rd_data_o = rx_buf_q;
      2'd1:    rd_data_o = ctrl_q;
      2'd2:    rd_data_o = {7'd0, dbl_q};
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o = int_en_i && (ctrl_q[CB_TX_DN] || ctrl_q[CB_RX_DN]);
endmodule

// File: rtl/sport_port_chk.sv
module sport_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       int_en_i,
  input logic       irq_o,
  input logic       txd_o,
  input logic       tx_busy,
  input logic       tx_done,
  input logic       rx_busy,
  input logic       rx_done,
  input logic [7:0] rx_buf_q,
  input logic [7:0] ctrl_q
);
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_en_i |-> !irq_o); // R11
  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl_q[1] || ctrl_q[2])); // R11
  AST_TXD_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o); // R6
  AST_TX_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done |=> ctrl_q[1]); // R2
  AST_RX_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done |=> ctrl_q[2]); // R8
  AST_RX_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_done |=> $stable(rx_buf_q)); // R8
  AST_RX_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_busy && !ctrl_q[5]) |=> !rx_busy); // R9
endmodule

bind sport_port sport_port_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .int_en_i (int_en_i),
  .irq_o    (irq_o),
  .txd_o    (txd_o),
  .tx_busy  (tx_busy),
  .tx_done  (tx_done),
  .rx_busy  (rx_busy),
  .rx_done  (rx_done),
  .rx_buf_q (rx_buf_q),
  .ctrl_q   (ctrl_q)
);

// File: tb/tb_sport_port.sv
module tb_sport_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       bit_wr_i = 1'b0;
  logic [2:0] bit_idx_i = '0;
  logic       bit_val_i = 1'b0;
  logic [1:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       t1_ovf_i = 1'b1;
  logic       t2_ovf_i = 1'b0;
  logic [1:0] t2_baud_en_i = '0;
  logic       int_en_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       txd_o;
  logic       irq_o;

  int total = 0, bad = 0;
  bit finished = 0;
  bit mon_en = 0;
  int cur_div = 16, cur_len = 10;
  logic [8:0] exp_q[$];

  sport_port dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic bwr(logic [2:0] i, logic v);
    @(negedge clk_i);
    bit_wr_i = 1'b1; bit_idx_i = i; bit_val_i = v;
    @(posedge clk_i);
    @(negedge clk_i);
    bit_wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    rd_addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  // scoreboard driver: push expected frame, then write the data register
  task automatic send(logic [7:0] d, logic n, int div, int len);
    cur_div = div; cur_len = len;
    exp_q.push_back({n, d});
    wr(2'd0, d);
  endtask

  // exact-cycle completion check, called right after send/wr returns
  task automatic flag_at(string tag, int cycles);
    logic [7:0] v;
    repeat (cycles - 1) @(posedge clk_i);
    @(negedge clk_i);
    rd(2'd1, v);
    check({tag, " done early"}, v[1], 1'b0);
    @(negedge clk_i);
    rd(2'd1, v);
    check({tag, " done on time"}, v[1], 1'b1);
  endtask

  task automatic drive_rx(int len, logic [10:0] bits, int div);
    @(negedge clk_i);
    for (int k = 0; k < len; k++) begin
      rxd_i = bits[k];
      repeat (div) @(negedge clk_i);
    end
    rxd_i = 1'b1;
  endtask

  // monitor: decode framed transmissions on txd_o and compare with the queue
  initial begin
    forever begin
      @(negedge clk_i);
      if (mon_en && txd_o === 1'b0) begin
        logic [10:0] f;
        logic [10:0] e;
        logic [8:0]  it;
        f = '1;
        repeat (cur_div / 2) @(negedge clk_i);
        for (int k = 0; k < cur_len; k++) begin
          f[k] = txd_o;
          if (k < cur_len - 1) repeat (cur_div) @(negedge clk_i);
        end
        if (exp_q.size() == 0) begin
          check("R6 unexpected frame", {21'd0, f}, 32'h7ff);
        end else begin
          it = exp_q.pop_front();
          if (cur_len == 10) e = {1'b1, 1'b1, it[7:0], 1'b0};
          else               e = {1'b1, it[8], it[7:0], 1'b0};
          if (cur_len == 10) f[10] = 1'b1;
          check("R6 frame bits", {21'd0, f}, {21'd0, e});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check("R1 txd idle", txd_o, 1'b1);
    check("R1 irq low", irq_o, 1'b0);
    rd(2'd0, v); check("R1 data reg", v, 8'h00);
    rd(2'd1, v); check("R1 ctrl reg", v, 8'h00);
    rd(2'd2, v); check("R1 rate reg", v, 8'h00);

    // R2 mode 1, rate-double, timer strobe held high
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h40);
    mon_en = 1;
    send(8'hA5, 1'b0, 16, 10);
    flag_at("R2 mode1", 160);
    wr(2'd1, 8'h40);
    send(8'h3C, 1'b0, 16, 10);
    repeat (170) @(negedge clk_i);
    rd(2'd1, v); check("R2 second frame done", v[1], 1'b1);

    // R3 mode 2 core clock, both rates, ninth bit
    wr(2'd1, 8'h90);
    send(8'h5A, 1'b1, 16, 11);
    flag_at("R3 mode2 fast", 176);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h80);
    send(8'hC3, 1'b0, 32, 11);
    flag_at("R3 mode2 slow", 352);
    repeat (20) @(negedge clk_i);

    // R5 second timer override in mode 1, rate-double clear
    t1_ovf_i = 1'b0; t2_ovf_i = 1'b1; t2_baud_en_i = 2'b10;
    wr(2'd1, 8'h40);
    send(8'h96, 1'b0, 16, 10);
    flag_at("R5 t2 override", 160);
    repeat (20) @(negedge clk_i);
    t2_baud_en_i = 2'b00; t2_ovf_i = 1'b0;

    // R4 mode 3 stalls without first-timer strobes
    mon_en = 0;
    wr(2'd2, 8'h01);
    wr(2'd1, 8'hC0);
    wr(2'd0, 8'h11);
    repeat (300) @(negedge clk_i);
    rd(2'd1, v); check("R4 stalled no done", v[1], 1'b0);
    check("R4 start bit held", txd_o, 1'b0);
    t1_ovf_i = 1'b1;
    repeat (11 * 16 + 5) @(negedge clk_i);
    rd(2'd1, v); check("R4 done after strobes", v[1], 1'b1);
    check("R4 line idle", txd_o, 1'b1);
    wr(2'd1, 8'hD0);
    mon_en = 1;
    send(8'hF0, 1'b1, 16, 11);
    repeat (190) @(negedge clk_i);

    // R7 mode 0 shift transmit
    mon_en = 0;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hB2);
    repeat (6) @(negedge clk_i);
    for (int k = 0; k < 8; k++) begin
      check($sformatf("R7 shift bit %0d", k), txd_o, (8'hB2 >> k) & 1);
      repeat (12) @(negedge clk_i);
    end
    rd(2'd1, v); check("R7 shift done", v[1], 1'b1);
    check("R7 line idle", txd_o, 1'b1);
    mon_en = 1;

    // R8 mode 1 receive, R11 interrupt gating
    wr(2'd1, 8'h60);
    drive_rx(10, {1'b1, 1'b1, 8'h5C, 1'b0}, 16);
    repeat (16) @(negedge clk_i);
    rd(2'd1, v); check("R8 rx done mode1", v[2], 1'b1);
    rd(2'd0, v); check("R8 rx data mode1", v, 8'h5C);
    check("R11 irq masked", irq_o, 1'b0);
    int_en_i = 1'b1;
    #1 check("R11 irq raised", irq_o, 1'b1);
    wr(2'd1, 8'h60);
    check("R11 irq cleared", irq_o, 1'b0);
    int_en_i = 1'b0;

    // R8 mode 3 ninth bit = 1, mode 2 ninth bit = 0
    wr(2'd1, 8'hE0);
    drive_rx(11, {1'b1, 1'b1, 8'h81, 1'b0}, 16);
    repeat (16) @(negedge clk_i);
    rd(2'd0, v); check("R8 rx data mode3", v, 8'h81);
    rd(2'd1, v); check("R8 rx ninth mode3", v[3], 1'b1);
    wr(2'd1, 8'hA0);
    drive_rx(11, {1'b1, 1'b0, 8'h42, 1'b0}, 16);
    repeat (16) @(negedge clk_i);
    rd(2'd0, v); check("R8 rx data mode2", v, 8'h42);
    rd(2'd1, v); check("R8 rx ninth mode2", v[3], 1'b0);

    // R9 receiver disabled
    wr(2'd1, 8'h40);
    drive_rx(10, {1'b1, 1'b1, 8'hFF, 1'b0}, 16);
    repeat (16) @(negedge clk_i);
    rd(2'd0, v); check("R9 buffer unchanged", v, 8'h42);
    rd(2'd1, v); check("R9 no rx done", v[2], 1'b0);

    // R12 single-bit writes
    bwr(3'd5, 1'b1);
    rd(2'd1, v); check("R12 bit write rx_en", v, 8'h60);
    drive_rx(10, {1'b1, 1'b1, 8'h37, 1'b0}, 16);
    repeat (16) @(negedge clk_i);
    rd(2'd0, v); check("R12 rx after bit write", v, 8'h37);
    bwr(3'd6, 1'b0);
    bwr(3'd7, 1'b1);
    bwr(3'd2, 1'b0);
    bwr(3'd5, 1'b0);
    rd(2'd1, v); check("R12 mode via bits", v, 8'h80);
    send(8'h2D, 1'b0, 16, 11);
    flag_at("R12 mode2 frame", 176);
    repeat (20) @(negedge clk_i);

    // R10 mode 0 receive starts on enable
    mon_en = 0;
    wr(2'd1, 8'h00);
    wr(2'd1, 8'h20);
    for (int k = 0; k < 8; k++) begin
      rxd_i = (8'h6D >> k) & 1;
      repeat (12) @(negedge clk_i);
    end
    rxd_i = 1'b1;
    repeat (4) @(negedge clk_i);
    rd(2'd1, v); check("R10 shift rx done", v[2], 1'b1);
    rd(2'd0, v); check("R10 shift rx data", v, 8'h6D);
    wr(2'd1, 8'h00);

    check("R6 all frames seen", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule